// File: doc/BRIEF.md
# Address-Keyed Data Pattern Generator and Checker

This block turns a beat address into a 64-bit data word. The word depends on the pattern mode and on a fixed slice of the address, bits 22 down to 2, which form a 21-bit word index. Nothing else affects it. A sender can therefore use the combinational output as its data source. A receiver on the far side of any data path can rebuild the same word from the address of each beat it receives, with no state shared between the two units.

In checking use, every beat marked valid is compared with the word rebuilt for its address. The result is reported one clock later on a mismatch flag. An error history records failures: a sticky flag, a saturating count of failing beats and the full address of the first failing beat. This history holds until a clear strobe wipes it.

The pattern modes are walking ones, walking zeros, ground bounce, a count keyed on the index, and a scrambled pseudo-random word that never repeats inside the 2M-word index space.

Top module: `addr_pattern_unit`

## Requirements
- R1: Mode 0 (walking ones) outputs a word with only bit (index mod 64) set. Mode 1 (walking zeros) outputs the bitwise inverse of that word. The index is addr[22:2].
- R2: Mode 2 (ground bounce) outputs all zeros when index bit 0 is 0 and all ones when it is 1.
- R3: Mode 3 (count) places the index, zero-extended to 32 bits, in both the upper half [63:32] and the lower half [31:0].
- R4: Mode 4 (scramble) takes x = index and applies, in 21-bit arithmetic, x ^= x<<7, then x ^= x>>5, then x ^= x<<3. The output is {11'b0, ~x, 11'b0, x}. Each step can be undone, so distinct indices give distinct words.
- R5: Mode codes 5, 6 and 7 output all zeros.
- R6: Address bits outside [22:2] have no effect on the generated word.
- R7: The mismatch output is 1 in the cycle after a valid beat whose data differs from the word generated for its address and mode. It is 0 after a matching beat and after any cycle with no valid beat.
- R8: The first mismatching beat sets the sticky error flag and latches its full 32-bit address. Later mismatches leave the latched address unchanged until a clear.
- R9: The error count rises by one for each mismatching beat and stops at its maximum (255 with default parameters).
- R10: A clear strobe zeroes the sticky flag, the count and the latched address. A mismatching beat in the same cycle as a clear is not recorded in the error history, but it still raises the mismatch output.
- R11: After reset, mismatch, the sticky flag, the count and the latched address are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Pattern mode select |
| addr | input | 32 | Beat address |
| beatValid | input | 1 | Marks a beat to be checked |
| beatData | input | 64 | Received data of the beat |
| clearErr | input | 1 | Wipes the error history |
| genData | output | 64 | Word generated for addr and mode (combinational) |
| mismatch | output | 1 | Registered compare result of the last cycle's beat |
| errSticky | output | 1 | Set by the first recorded mismatch |
| errCount | output | 8 | Saturating count of recorded mismatches |
| firstFailAddr | output | 32 | Address of the first recorded mismatch |

## Verification
The assertions check on every cycle that the walking-ones word has exactly one bit set and that walking zeros has exactly one bit clear. They also check that the mismatch flag never rises without a beat, that the sticky flag and the latched address hold between clears, that the count stays at its maximum once saturated, and that the count is nonzero exactly when the sticky flag is set. Only the bench scenarios can show that each mode produces the exact expected word, that high address bits are ignored, which beat's address gets latched, and how a clear and a failing beat in the same cycle interact.

// File: rtl/apg_pkg.sv
package apg_pkg;

  typedef enum logic [2:0] {
    PAT_WALK1    = 3'd0,
    PAT_WALK0    = 3'd1,
    PAT_BOUNCE   = 3'd2,
    PAT_COUNT    = 3'd3,
    PAT_SCRAMBLE = 3'd4
  } patMode_e;

  // Strobes from control to datapath for the error history
  typedef struct packed {
    logic wipe;        // clear history
    logic latchAddr;   // capture failing address
    logic bumpCount;   // increment error count
  } errCtl_t;

endpackage

// File: rtl/apg_datapath.sv
module apg_datapath
  import apg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int IDX_LO = 2,
  parameter int IDX_HI = 22,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              beatValid,
  input  logic [DATA_W-1:0] beatData,
  input  errCtl_t           ctl,
  output logic [DATA_W-1:0] genData,
  output logic              missNow,
  output logic              mismatch,
  output logic              cntFull,
  output logic [CNT_W-1:0]  errCount,
  output logic [ADDR_W-1:0] firstFailAddr
);

  localparam int IDX_W  = IDX_HI - IDX_LO + 1;
  localparam int HALF_W = DATA_W / 2;
  localparam int PAD_W  = HALF_W - IDX_W;
  localparam int WSEL_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [IDX_W-1:0]  wordIdx;
  logic [DATA_W-1:0] walkWord;
  logic [DATA_W-1:0] bounceWord;
  logic [DATA_W-1:0] countWord;
  logic [DATA_W-1:0] scrWord;
  logic [IDX_W-1:0]  scrStage [4];

  assign wordIdx = addr[IDX_HI:IDX_LO];

  // One-hot decoder for the walking patterns
  for (genvar b = 0; b < DATA_W; b++) begin : g_walk
    assign walkWord[b] = (wordIdx[WSEL_W-1:0] == WSEL_W'(b));
  end

  assign bounceWord = {DATA_W{wordIdx[0]}};
  assign countWord  = {{PAD_W{1'b0}}, wordIdx, {PAD_W{1'b0}}, wordIdx};

  // Three reversible xor-shift steps over the index width
  assign scrStage[0] = wordIdx;
  assign scrStage[1] = scrStage[0] ^ (scrStage[0] << 7);
  assign scrStage[2] = scrStage[1] ^ (scrStage[1] >> 5);
  assign scrStage[3] = scrStage[2] ^ (scrStage[2] << 3);
  assign scrWord     = {{PAD_W{1'b0}}, ~scrStage[3], {PAD_W{1'b0}}, scrStage[3]};

  always_comb begin
    unique case (patMode_e'(mode))
      PAT_WALK1:    genData = walkWord;
      PAT_WALK0:    genData = ~walkWord;
      PAT_BOUNCE:   genData = bounceWord;
      PAT_COUNT:    genData = countWord;
      PAT_SCRAMBLE: genData = scrWord;
      default:      genData = '0;
    endcase
  end

  assign missNow = beatValid && (beatData != genData);
  assign cntFull = (errCount == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mismatch      <= 1'b0;
      errCount      <= '0;
      firstFailAddr <= '0;
    end else begin
      mismatch <= missNow;
      if (ctl.wipe) begin
        errCount      <= '0;
        firstFailAddr <= '0;
      end else begin
        if (ctl.bumpCount) errCount <= errCount + 1'b1;
        if (ctl.latchAddr) firstFailAddr <= addr;
      end
    end
  end

endmodule

// File: rtl/apg_control.sv
module apg_control
  import apg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clearErr,
  input  logic    missNow,
  input  logic    cntFull,
  output errCtl_t ctl,
  output logic    errSticky
);

  logic recordMiss;

  assign recordMiss    = missNow && !clearErr;
  assign ctl.wipe      = clearErr;
  assign ctl.latchAddr = recordMiss && !errSticky;
  assign ctl.bumpCount = recordMiss && !cntFull;

  always_ff @(posedge clk) begin
    if (!rst_n)          errSticky <= 1'b0;
    else if (clearErr)   errSticky <= 1'b0;
    else if (recordMiss) errSticky <= 1'b1;
  end

endmodule

// File: rtl/addr_pattern_unit.sv
module addr_pattern_unit
  import apg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int IDX_LO = 2,
  parameter int IDX_HI = 22,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              beatValid,
  input  logic [DATA_W-1:0] beatData,
  input  logic              clearErr,
  output logic [DATA_W-1:0] genData,
  output logic              mismatch,
  output logic              errSticky,
  output logic [CNT_W-1:0]  errCount,
  output logic [ADDR_W-1:0] firstFailAddr
);

  errCtl_t ctl;
  logic    missNow;
  logic    cntFull;

  apg_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_LO(IDX_LO),
    .IDX_HI(IDX_HI), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr),
    .beatValid(beatValid), .beatData(beatData), .ctl(ctl),
    .genData(genData), .missNow(missNow), .mismatch(mismatch),
    .cntFull(cntFull), .errCount(errCount), .firstFailAddr(firstFailAddr)
  );

  apg_control u_ctl (
    .clk(clk), .rst_n(rst_n), .clearErr(clearErr), .missNow(missNow),
    .cntFull(cntFull), .ctl(ctl), .errSticky(errSticky)
  );

endmodule

// File: rtl/apg_checks.sv
module apg_checks #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              beatValid,
  input logic              clearErr,
  input logic [DATA_W-1:0] genData,
  input logic              mismatch,
  input logic              errSticky,
  input logic [CNT_W-1:0]  errCount,
  input logic [ADDR_W-1:0] firstFailAddr
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  p_walk1_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |-> ($countones(genData) == 1));

  p_walk0_onecold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1) |-> ($countones(~genData) == 1));

  p_no_beat_no_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !beatValid |=> !mismatch);

  p_sticky_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (errSticky && !clearErr) |=> errSticky);

  p_first_addr_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (errSticky && !clearErr) |=> $stable(firstFailAddr));

  p_count_saturates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (errCount == CNT_TOP && !clearErr) |=> (errCount == CNT_TOP));

  p_count_tracks_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (errCount != '0) == errSticky);

  p_clear_wipes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clearErr |=> (!errSticky && errCount == '0 && firstFailAddr == '0));

endmodule

bind addr_pattern_unit apg_checks #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .beatValid(beatValid),
  .clearErr(clearErr), .genData(genData), .mismatch(mismatch),
  .errSticky(errSticky), .errCount(errCount), .firstFailAddr(firstFailAddr)
);

// File: tb/addr_pattern_unit_tb.sv
module addr_pattern_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic [31:0] addr;
  logic        beatValid;
  logic [63:0] beatData;
  logic        clearErr;
  logic [63:0] genData;
  logic        mismatch;
  logic        errSticky;
  logic [7:0]  errCount;
  logic [31:0] firstFailAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  addr_pattern_unit u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr),
    .beatValid(beatValid), .beatData(beatData), .clearErr(clearErr),
    .genData(genData), .mismatch(mismatch), .errSticky(errSticky),
    .errCount(errCount), .firstFailAddr(firstFailAddr)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  mode;
    logic [31:0] addr;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 3'd0, 32'h0000_0004, 64'h0000_0000_0000_0002},  // R1 index 1
    '{8'd1, 3'd0, 32'h0000_00FC, 64'h8000_0000_0000_0000},  // R1 index 63
    '{8'd1, 3'd0, 32'h0000_0100, 64'h0000_0000_0000_0001},  // R1 wraps at 64
    '{8'd1, 3'd1, 32'h0000_0008, 64'hFFFF_FFFF_FFFF_FFFB},  // R1 walking zeros
    '{8'd2, 3'd2, 32'h0000_0000, 64'h0000_0000_0000_0000},  // R2 even index
    '{8'd2, 3'd2, 32'h0000_0004, 64'hFFFF_FFFF_FFFF_FFFF},  // R2 odd index
    '{8'd3, 3'd3, 32'h0000_0010, 64'h0000_0004_0000_0004},  // R3
    '{8'd3, 3'd3, 32'h007F_FFFC, 64'h001F_FFFF_001F_FFFF},  // R3 top index
    '{8'd4, 3'd4, 32'h0000_0000, 64'h001F_FFFF_0000_0000},  // R4 zero index
    '{8'd5, 3'd5, 32'h0000_0010, 64'h0000_0000_0000_0000},  // R5
    '{8'd5, 3'd7, 32'h0000_0104, 64'h0000_0000_0000_0000},  // R5
    '{8'd6, 3'd3, 32'hFF80_0013, 64'h0000_0004_0000_0004}   // R6 high/low bits ignored
  };

  function automatic logic [63:0] scrModel(input logic [31:0] a);
    logic [20:0] x;
    x = a[22:2];
    x = x ^ (x << 7);
    x = x ^ (x >> 5);
    x = x ^ (x << 3);
    return {11'b0, ~x, 11'b0, x};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One beat: drive at negedge, result visible at the following negedge
  task automatic beat(input logic [2:0] m, input logic [31:0] a, input logic [63:0] d,
                      input logic clr);
    @(negedge clk);
    mode = m; addr = a; beatData = d; beatValid = 1'b1; clearErr = clr;
    @(negedge clk);
    beatValid = 1'b0; clearErr = 1'b0;
  endtask

  task automatic doClear();
    @(negedge clk);
    clearErr = 1'b1;
    @(negedge clk);
    clearErr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 3'd0; addr = '0; beatValid = 1'b0;
    beatData = '0; clearErr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 mismatch", 64'(mismatch), 64'd0);
    chk("R11 sticky",   64'(errSticky), 64'd0);
    chk("R11 count",    64'(errCount), 64'd0);
    chk("R11 addr",     64'(firstFailAddr), 64'd0);

    // Vector table: generated word per mode and address
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode = VECS[i].mode; addr = VECS[i].addr;
      #1;
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), genData, VECS[i].exp);
    end

    // R4 scramble against model over spread addresses
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a;
      a = 32'h0013_5A00 * (i + 1) + 32'(i * 4);
      @(negedge clk);
      mode = 3'd4; addr = a;
      #1;
      chk("R4 scramble model", genData, scrModel(a));
    end
    // R4 neighbours differ
    begin
      logic [63:0] w0;
      @(negedge clk); mode = 3'd4; addr = 32'h0000_0400; #1; w0 = genData;
      @(negedge clk); addr = 32'h0000_0404; #1;
      chk("R4 distinct", 64'(genData != w0), 64'd1);
    end

    // R7 matching beat
    beat(3'd3, 32'h0000_0020, 64'h0000_0008_0000_0008, 1'b0);
    chk("R7 match no flag", 64'(mismatch), 64'd0);
    chk("R8 no sticky on match", 64'(errSticky), 64'd0);

    // R7/R8/R9 first failing beat
    beat(3'd0, 32'h0000_0A04, 64'h0, 1'b0);
    chk("R7 miss flag", 64'(mismatch), 64'd1);
    chk("R8 sticky", 64'(errSticky), 64'd1);
    chk("R8 first addr", 64'(firstFailAddr), 64'h0000_0A04);
    chk("R9 count 1", 64'(errCount), 64'd1);
    @(negedge clk);
    chk("R7 idle clears flag", 64'(mismatch), 64'd0);

    // R8 second failure keeps first address
    beat(3'd2, 32'hC000_0004, 64'h0, 1'b0);
    chk("R8 addr held", 64'(firstFailAddr), 64'h0000_0A04);
    chk("R9 count 2", 64'(errCount), 64'd2);

    // R10 clear
    doClear();
    chk("R10 sticky wiped", 64'(errSticky), 64'd0);
    chk("R10 count wiped", 64'(errCount), 64'd0);
    chk("R10 addr wiped", 64'(firstFailAddr), 64'd0);

    // R10 clear and failing beat together
    beat(3'd3, 32'h0000_0040, 64'h1, 1'b1);
    chk("R10 same-cycle miss flag", 64'(mismatch), 64'd1);
    chk("R10 same-cycle not recorded", 64'(errCount), 64'd0);
    chk("R10 same-cycle sticky", 64'(errSticky), 64'd0);

    // R9 saturation with back-to-back failing beats
    @(negedge clk);
    mode = 3'd3; beatData = 64'h0; beatValid = 1'b1;
    for (int i = 0; i < 260; i++) begin
      addr = 32'h0000_1000 + 32'(i * 4);
      @(negedge clk);
    end
    beatValid = 1'b0;
    @(negedge clk);
    chk("R9 saturated", 64'(errCount), 64'd255);
    chk("R8 first of burst", 64'(firstFailAddr), 64'h0000_1000);
    doClear();
    chk("R10 clear after saturation", 64'(errCount), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule